// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block is a single-channel, single-rate FIR filter that uses no multipliers. Each accepted sample enters a tap history. The engine then walks the bit positions of the stored samples, one position per clock. At each position, the bits that all taps hold there form addresses into small tables of precomputed coefficient sums. The table outputs are added together, weighted by the bit position, and collected in a full-precision accumulator. The sign position is handled last and is subtracted.

Taps are grouped four to a table, and each table has sixteen entries. Coefficient values are a parameter vector, and the tables are built from it when the design is elaborated. When the tap count is not a multiple of four, the unused table slots hold zero. The clock runs far faster than the sample rate, so one result per sample needs only DATA_W cycles of work.

The sum carries COEF_FRAC + DATA_FRAC fractional bits. It is narrowed to OUT_W bits with OUT_FRAC fractional bits. The low bits are cut off, which rounds toward minus infinity. The high bits are dropped, so an overflow wraps.

Top module: `da_fir`

## Requirements
- R1: While rst_ni is low, valid_o and data_o are 0 and the tap history is cleared. Outputs after reset therefore use zero for every sample that came before reset.
- R2: When valid_i is high at a rising edge and the engine is idle, data_i (two's complement) is accepted. It becomes the newest tap, and every older tap moves back one place.
- R3: A valid_i pulse that arrives while the engine is busy has no effect on the history or on any result. This includes a pulse in the cycle that processes the last bit position.
- R4: valid_o is high for exactly one cycle. It rises DATA_W clock edges after the edge that accepted the sample.
- R5: The full sum is S = sum over k of c[k]*x[n-k]. Each c[k] is a signed COEF_W-bit integer held at bits [k*COEF_W +: COEF_W] of COEFS, and x[n-k] is the k-th newest accepted sample. data_o equals bits [DROP +: OUT_W] of S, where DROP = COEF_FRAC + DATA_FRAC - OUT_FRAC (12 with the defaults).
- R6: The discarded low bits are truncated, not rounded. A negative sum that is not exact therefore rounds toward minus infinity, so S = -2047 gives data_o = -1.
- R7: If the scaled sum goes past the range of the output, data_o wraps modulo 2^OUT_W and does not saturate.
- R8: data_o holds its value in every cycle in which valid_o is low.
- R9: A valid_i in the same cycle as valid_o is accepted, because the engine is already idle in that cycle.
- R10: The most significant input bit is weighted negatively. The input -2^(DATA_W-1) is therefore treated as the most negative value.
- R11: When NUM_TAPS is not a multiple of GROUP_SIZE, the unused table slots contribute nothing to S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| data_i | input | DATA_W | Input sample, signed, DATA_FRAC fractional bits |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | OUT_W | Filtered output, signed, OUT_FRAC fractional bits |

## Verification
Two things can happen in the same cycle: the engine finishes a result, and a new sample strobe arrives. The outcome depends on the exact cycle of the strobe.

The bench places valid_i in each busy cycle, including the cycle that processes the last bit. It then judges the result of each case:
- The history model leaves the strobed value out, and every later output must match that model.
- The reported latency must stay at DATA_W.

A second case puts valid_i in the cycle where valid_o is high. There the value must be taken in, and its result must appear after exactly DATA_W further edges.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  localparam int DEF_TAPS   = 92;
  localparam int DEF_COEF_W = 12;

  typedef struct packed {
    logic active;
    logic first;
    logic last;
  } step_t;

  // Placeholder coefficient set, all values kept within about +/-0.15
  function automatic logic [DEF_TAPS*DEF_COEF_W-1:0] default_coefs();
    logic [DEF_TAPS*DEF_COEF_W-1:0] v;
    v = '0;
    for (int k = 0; k < DEF_TAPS; k++) begin
      int c;
      c = ((k * 73 + 19) % 1201) - 600;
      v[k*DEF_COEF_W +: DEF_COEF_W] = DEF_COEF_W'(c);
    end
    return v;
  endfunction

endpackage

// File: rtl/da_fir_taps.sv
module da_fir_taps #(
  parameter int NUM_TAPS = 92,
  parameter int PAD_TAPS = 92,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic [DATA_W-1:0]   sample_i,
  input  logic [SEL_W-1:0]    bit_sel_i,
  output logic [PAD_TAPS-1:0] bits_o
);

  logic [DATA_W-1:0] tap_q [NUM_TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_TAPS; k++) tap_q[k] <= '0;
    end else if (shift_i) begin
      tap_q[0] <= sample_i;
      for (int k = 1; k < NUM_TAPS; k++) tap_q[k] <= tap_q[k-1];
    end
  end

  for (genvar k = 0; k < PAD_TAPS; k++) begin : g_bit
    if (k < NUM_TAPS) begin : g_real
      assign bits_o[k] = tap_q[k][bit_sel_i];
    end else begin : g_pad
      assign bits_o[k] = 1'b0;
    end
  end

endmodule

// File: rtl/da_fir_lut.sv
module da_fir_lut #(
  parameter int                        GROUP   = 4,
  parameter int                        COEF_W  = 12,
  parameter int                        PART_W  = 15,
  parameter logic [GROUP*COEF_W-1:0]   COEFS_G = '0
) (
  input  logic [GROUP-1:0]          addr_i,
  output logic signed [PART_W-1:0]  part_o
);

  localparam int ENTRIES = 2 ** GROUP;

  function automatic int entry_sum(int e);
    int s;
    s = 0;
    for (int j = 0; j < GROUP; j++)
      if (((e >> j) & 1) == 1) s += int'(signed'(COEFS_G[j*COEF_W +: COEF_W]));
    return s;
  endfunction

  logic signed [PART_W-1:0] rom [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_rom
    assign rom[e] = PART_W'(entry_sum(e));
  end

  assign part_o = rom[addr_i];

endmodule

// File: rtl/da_fir_acc.sv
module da_fir_acc #(
  parameter int ACC_W  = 33,
  parameter int PART_W = 20,
  parameter int SEL_W  = 3,
  parameter int OUT_W  = 8,
  parameter int DROP   = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  da_fir_pkg::step_t         step_i,
  input  logic [SEL_W-1:0]          bit_idx_i,
  input  logic signed [PART_W-1:0]  part_i,
  output logic                      valid_o,
  output logic [OUT_W-1:0]          data_o
);

  logic signed [ACC_W-1:0] acc_q, acc_d, term, base;

  always_comb begin
    term  = ACC_W'(part_i) <<< bit_idx_i;
    base  = step_i.first ? '0 : acc_q;
    // sign position carries negative weight
    acc_d = step_i.last ? base - term : base + term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= step_i.active && step_i.last;
      if (step_i.active) acc_q <= acc_d;
      if (step_i.active && step_i.last) data_o <= acc_d[DROP +: OUT_W];
    end
  end

  assert_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

endmodule

// File: rtl/da_fir.sv
module da_fir #(
  parameter int NUM_TAPS   = 92,
  parameter int GROUP_SIZE = 4,
  parameter int COEF_W     = 12,
  parameter int COEF_FRAC  = 12,
  parameter int DATA_W     = 8,
  parameter int DATA_FRAC  = 6,
  parameter int OUT_W      = 8,
  parameter int OUT_FRAC   = 6,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = da_fir_pkg::default_coefs()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  data_o
);

  localparam int NUM_GROUPS = (NUM_TAPS + GROUP_SIZE - 1) / GROUP_SIZE;
  localparam int PAD_TAPS   = NUM_GROUPS * GROUP_SIZE;
  localparam int SEL_W      = $clog2(DATA_W);
  localparam int PART_W     = COEF_W + $clog2(GROUP_SIZE) + 1;
  localparam int TREE_W     = COEF_W + $clog2(PAD_TAPS) + 1;
  localparam int ACC_W      = TREE_W + DATA_W + 1;
  localparam int DROP       = COEF_FRAC + DATA_FRAC - OUT_FRAC;

  function automatic logic [GROUP_SIZE*COEF_W-1:0] group_coefs(int g);
    logic [GROUP_SIZE*COEF_W-1:0] v;
    v = '0;
    for (int j = 0; j < GROUP_SIZE; j++)
      if (g * GROUP_SIZE + j < NUM_TAPS)
        v[j*COEF_W +: COEF_W] = COEFS[(g*GROUP_SIZE+j)*COEF_W +: COEF_W];
    return v;
  endfunction

  logic             busy_q;
  logic [SEL_W-1:0] cnt_q;
  logic             accept_w, last_w;
  da_fir_pkg::step_t step_w;

  assign accept_w = valid_i && !busy_q;
  assign last_w   = busy_q && (cnt_q == SEL_W'(DATA_W - 1));
  assign step_w   = '{active: busy_q, first: busy_q && (cnt_q == '0), last: last_w};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_w) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      busy_q <= !last_w;
      cnt_q  <= last_w ? '0 : cnt_q + 1'b1;
    end
  end

  logic [PAD_TAPS-1:0] bits_w;

  da_fir_taps #(
    .NUM_TAPS (NUM_TAPS),
    .PAD_TAPS (PAD_TAPS),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W)
  ) u_taps (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (accept_w),
    .sample_i  (data_i),
    .bit_sel_i (cnt_q),
    .bits_o    (bits_w)
  );

  logic signed [PART_W-1:0] part_w [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    da_fir_lut #(
      .GROUP   (GROUP_SIZE),
      .COEF_W  (COEF_W),
      .PART_W  (PART_W),
      .COEFS_G (group_coefs(g))
    ) u_lut (
      .addr_i (bits_w[g*GROUP_SIZE +: GROUP_SIZE]),
      .part_o (part_w[g])
    );
  end

  logic signed [TREE_W-1:0] tree_w;

  always_comb begin
    tree_w = '0;
    for (int g = 0; g < NUM_GROUPS; g++) tree_w = tree_w + TREE_W'(part_w[g]);
  end

  da_fir_acc #(
    .ACC_W  (ACC_W),
    .PART_W (TREE_W),
    .SEL_W  (SEL_W),
    .OUT_W  (OUT_W),
    .DROP   (DROP)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_w),
    .bit_idx_i (cnt_q),
    .part_i    (tree_w),
    .valid_o   (valid_o),
    .data_o    (data_o)
  );

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !busy_q) |=> (busy_q && cnt_q == '0));

  assert_ignore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && busy_q && !last_w) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(last_w));

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < DATA_W);

endmodule

// File: tb/da_fir_tb.sv
module da_fir_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;
  localparam int CW = 12;
  // c0..c5 = 2047, 2047, 1900, -2048, 1500, -300
  localparam logic [NT*CW-1:0] TB_COEFS =
    {12'hED4, 12'h5DC, 12'h800, 12'h76C, 12'h7FF, 12'h7FF};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [7:0] data_i = '0;
  logic valid_o;
  logic [7:0] data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  da_fir #(
    .NUM_TAPS (NT), .GROUP_SIZE (4), .COEF_W (CW), .COEF_FRAC (12),
    .DATA_W (8), .DATA_FRAC (6), .OUT_W (8), .OUT_FRAC (6), .COEFS (TB_COEFS)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i), .data_i (data_i),
    .valid_o (valid_o), .data_o (data_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic signed [7:0] hist [NT];
  logic [7:0] prev_out = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp));
    end
  endtask

  function automatic logic [7:0] model();
    longint s;
    logic [63:0] b;
    s = 0;
    for (int k = 0; k < NT; k++)
      s += longint'($signed(TB_COEFS[k*CW +: CW])) * longint'(hist[k]);
    b = 64'(s);
    return b[19:12];
  endfunction

  function automatic logic [7:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    @(negedge clk);
    check("R1 valid_o in reset", {7'd0, valid_o}, 8'd0);
    check("R1 data_o in reset", data_o, 8'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < NT; k++) hist[k] = '0;
    prev_out = '0;
  endtask

  // probe_at: busy-cycle index for an extra strobe that must be ignored (-1 none)
  task automatic apply(input logic [7:0] x, input int probe_at, input logic [7:0] probe_x,
                       input bit immediate, input string tag);
    int n;
    if (!immediate) begin
      @(negedge clk);
      check({tag, " R4 valid_o low"}, {7'd0, valid_o}, 8'd0);
      check({tag, " R8 hold"}, data_o, prev_out);
    end
    valid_i = 1'b1;
    data_i = x;
    for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    @(negedge clk);
    n = 0;
    while (!valid_o) begin
      if (n == probe_at) begin
        valid_i = 1'b1;
        data_i = probe_x;
      end else begin
        valid_i = 1'b0;
      end
      @(negedge clk);
      n++;
      if (n > 40) begin
        check({tag, " watchdog"}, 8'd1, 8'd0);
        break;
      end
    end
    valid_i = 1'b0;
    check({tag, " R4 latency"}, 8'(n), 8'd8);
    check({tag, " R5 value"}, data_o, model());
    prev_out = data_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NT; k++) hist[k] = '0;
    do_reset();
    // R10: most negative input, -128*2047 -> -64
    apply(8'h80, -1, 8'h00, 1'b0, "R10 neg full scale");
    check("R10 literal", data_o, 8'hC0);
    for (int i = 0; i < NT; i++) apply(8'h00, -1, 8'h00, 1'b0, "R11 flush");

    do_reset();
    // R6: -1 * 2047 = -2047 -> floor gives -1
    apply(8'hFF, -1, 8'h00, 1'b0, "R6 truncate");
    check("R6 literal", data_o, 8'hFF);

    do_reset();
    for (int i = 0; i < NT; i++) apply(8'h7F, -1, 8'h00, 1'b0, "R7 wrap");
    check("R7 literal", data_o, 8'h9F);
    check("R8 hold after result", data_o, prev_out);

    // exhaustive input sweep
    for (int v = 0; v < 256; v++) apply(8'(v), -1, 8'h00, 1'b0, "R2 sweep");

    // strobes inside every busy cycle, including the last bit
    for (int rep = 0; rep < 4; rep++)
      for (int p = 0; p < 8; p++) apply(next_rand(), p, next_rand(), 1'b0, "R3 probe");

    // strobe in the cycle valid_o is high
    for (int i = 0; i < 24; i++) apply(next_rand(), -1, 8'h00, 1'b1, "R9 chain");

    for (int i = 0; i < 300; i++) apply(next_rand(), -1, 8'h00, 1'b0, "R5 random");

    // mid-stream reset clears history
    do_reset();
    apply(8'h01, -1, 8'h00, 1'b0, "R1 history cleared");
    for (int i = 0; i < NT; i++) apply(next_rand(), -1, 8'h00, 1'b0, "R1 refill");

    repeat (5) begin
      @(negedge clk);
      check("R8 idle hold", data_o, prev_out);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule